// File: doc/BRIEF.md
# Firmware Memory Cycle Target

This block answers firmware memory read and firmware memory write cycles on a four-bit multiplexed LPC bus. It stores the data in a small on-chip byte array that takes the place of a boot flash device. Each cycle carries a start nibble, a device-select nibble, a 28-bit address and a size code. When the device select matches the strap input and the request is legal, the block serves a burst of 1, 2, 4, 16 or 128 bytes. On a read it drives a ready SYNC and then the data. On a write it takes the data from the host and then confirms the cycle with SYNC.

The host owns the frame line. The block watches it on every clock. Pulling it low at any point abandons the current cycle and starts the decode of a new one. A request with a foreign device select, an unknown size code or an address not aligned to the burst size is ignored: the block never drives the bus for it. The array is indexed by the low bits of the address, so higher address bits alias onto the same bytes.

Top module: `fwmem_target`

## Requirements
- R1: Out of reset `lad_oe` is low, and it stays low until a valid cycle addressed to this device reaches its SYNC slot.
- R2: With `frame_n` low, lad_in 4'hD starts a read cycle and 4'hE starts a write cycle. Any other nibble starts nothing. If `frame_n` stays low for several clocks, the nibble on the last low clock decides.
- R3: The nibble after the start is a device select. A cycle whose select differs from `dev_id` gets no bus drive and leaves the array unchanged.
- R4: The next seven nibbles form a 28-bit address, most significant nibble first. Only the low log2(MEM_BYTES) bits pick the byte, so higher bits alias.
- R5: The nibble after the address is the size code: 4'h0 = 1, 4'h1 = 2, 4'h2 = 4, 4'h4 = 16, 4'h7 = 128 bytes. Any other code gets no response and no write.
- R6: An address that is not a multiple of the burst size gets no response and no write.
- R7: On a read the host spends two turnaround clocks. The block then drives 4'h0 for one clock, then each byte low nibble first in ascending address order, then 4'hF for one clock, and then releases the bus.
- R8: On a write the host sends each byte low nibble first in ascending address order, then two turnaround clocks. The block then drives 4'h0 for one clock, then 4'hF for one clock, and then releases the bus. The written bytes can be read back.
- R9: `frame_n` low during any clock of a cycle aborts it, and the bus is released on the next clock. In an aborted write, the bytes whose two nibbles were both received are kept, and a half-received byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 4 | Strap value the device-select nibble must match |
| frame_n | input | 1 | Active-low frame from the host |
| lad_in | input | 4 | Nibble the host drives on the bus |
| lad_out | output | 4 | Nibble the block drives on the bus |
| lad_oe | output | 1 | High while the block drives the bus |

## Verification
The bound checker watches every clock for the following:
- the bus is quiet after reset;
- the first driven nibble of any response is the ready SYNC;
- the last driven nibble before a normal release is 4'hF;
- the bus is always released on the clock after a low frame;
- no drive run is longer than a 128-byte read needs.

Only the bench scenarios can show the rest:
- the data order;
- the address aliasing;
- that rejected requests (foreign select, bad size code, misaligned address, foreign start code) leave the array untouched;
- which bytes survive an aborted write.
The bench shows these by reading the array back through ordinary read cycles.

// File: rtl/fwmem_target.sv
module fwmem_target #(
  parameter int MEM_BYTES = 256,
  parameter logic [3:0] RD_CODE = 4'hD,
  parameter logic [3:0] WR_CODE = 4'hE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dev_id,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe
);
  localparam int AW = $clog2(MEM_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_ADDR, S_SIZE, S_TAR, S_SYNC, S_RDATA, S_WDATA, S_END
  } state_t;

  state_t          state;
  logic [7:0]      cnt;
  logic            is_wr;
  logic            hit;
  logic [AW-1:0]   addr;
  logic [7:0]      nbytes;
  logic [3:0]      wlo;
  logic [7:0]      sz_bytes;
  logic            align_ok;
  logic            last_nib;
  logic [AW-1:0]   idx;
  logic [7:0]      rbyte;
  logic [7:0]      mem [MEM_BYTES];

  always_comb begin
    case (lad_in)
      4'h0:    sz_bytes = 8'd1;
      4'h1:    sz_bytes = 8'd2;
      4'h2:    sz_bytes = 8'd4;
      4'h4:    sz_bytes = 8'd16;
      4'h7:    sz_bytes = 8'd128;
      default: sz_bytes = 8'd0;
    endcase
  end

  assign align_ok = (addr[6:0] & (sz_bytes[6:0] - 7'd1)) == 7'd0;
  assign last_nib = {1'b0, cnt} == ({nbytes, 1'b0} - 9'd1);
  assign idx      = addr + AW'(cnt[7:1]);
  assign rbyte    = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      is_wr  <= 1'b0;
      hit    <= 1'b0;
      addr   <= '0;
      nbytes <= '0;
      wlo    <= '0;
    end else if (!frame_n) begin
      state <= (lad_in == RD_CODE || lad_in == WR_CODE) ? S_SEL : S_IDLE;
      is_wr <= lad_in == WR_CODE;
      cnt   <= '0;
    end else begin
      case (state)
        S_SEL: begin
          hit   <= lad_in == dev_id;
          cnt   <= '0;
          state <= S_ADDR;
        end
        S_ADDR: begin
          addr <= AW'({addr, lad_in});
          cnt  <= cnt + 8'd1;
          if (cnt == 8'd6) state <= S_SIZE;
        end
        S_SIZE: begin
          nbytes <= sz_bytes;
          cnt    <= '0;
          if (hit && sz_bytes != 8'd0 && align_ok)
            state <= is_wr ? S_WDATA : S_TAR;
          else
            state <= S_IDLE;
        end
        S_TAR: begin
          cnt <= cnt + 8'd1;
          if (cnt[0]) begin
            cnt   <= '0;
            state <= S_SYNC;
          end
        end
        S_SYNC: begin
          cnt   <= '0;
          state <= is_wr ? S_END : S_RDATA;
        end
        S_RDATA: begin
          cnt <= cnt + 8'd1;
          if (last_nib) state <= S_END;
        end
        S_WDATA: begin
          if (!cnt[0]) wlo <= lad_in;
          cnt <= cnt + 8'd1;
          if (last_nib) begin
            cnt   <= '0;
            state <= S_TAR;
          end
        end
        S_END:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_WDATA && frame_n && cnt[0])
      mem[idx] <= {lad_in, wlo};
  end

  assign lad_oe = state == S_SYNC || state == S_RDATA || state == S_END;

  always_comb begin
    case (state)
      S_RDATA: lad_out = cnt[0] ? rbyte[7:4] : rbyte[3:0];
      S_END:   lad_out = 4'hF;
      default: lad_out = 4'h0;
    endcase
  end
endmodule

// File: rtl/fwmem_target_chk.sv
module fwmem_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe
);
  logic [8:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= '0;
    else if (lad_oe) run <= run + 9'd1;
    else             run <= '0;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lad_oe);

  assert_sync_leads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == 4'h0);

  assert_high_before_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lad_oe) && $past(frame_n)) |-> $past(lad_out) == 4'hF);

  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  assert_drive_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 9'd258);
endmodule

bind fwmem_target fwmem_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_out(lad_out), .lad_oe(lad_oe)
);

// File: tb/fwmem_target_bench.sv
module fwmem_target_bench;
  localparam logic [3:0] DEV = 4'h3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe;

  int checks = 0;
  int errors = 0;
  logic       got_oe;
  logic [3:0] got_dat;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [128];

  always #5 clk = ~clk;

  fwmem_target u_fwmem_target (
    .clk(clk), .rst_n(rst_n), .dev_id(DEV), .frame_n(frame_n),
    .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic f, input logic [3:0] v);
    @(negedge clk);
    got_oe  = lad_oe;
    got_dat = lad_out;
    frame_n = f;
    lad_in  = v;
  endtask

  task automatic header(input logic [3:0] code, input logic [3:0] id, input logic [27:0] a, input logic [3:0] szc);
    slot(1'b0, code);
    slot(1'b1, id);
    for (int i = 6; i >= 0; i--) slot(1'b1, a[4*i +: 4]);
    slot(1'b1, szc);
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) wbuf[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
  endtask

  task automatic do_read(input logic [3:0] id, input logic [27:0] a, input logic [3:0] szc,
                         input int n, input bit resp, input string tag);
    bit quiet = 1'b1;
    header(4'hD, id, a, szc);
    if (!resp) begin
      for (int i = 0; i < 2 * n + 5; i++) begin
        slot(1'b1, 4'hF);
        if (got_oe) quiet = 1'b0;
      end
      chk(quiet, {tag, " rejected read stays off bus"}, quiet, 1);
      return;
    end
    slot(1'b1, 4'hF);
    chk(!got_oe, {tag, " turnaround undriven"}, got_oe, 0);
    slot(1'b1, 4'hF);
    slot(1'b1, 4'hF);
    chk(got_oe && got_dat == 4'h0, {tag, " R7 sync nibble"}, {got_oe, got_dat}, 5'h10);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e = exp_mem[8'(a[7:0] + 8'(i))];
      slot(1'b1, 4'hF);
      chk(got_oe && got_dat == e[3:0], {tag, " R7 low nibble"}, {got_oe, got_dat}, {1'b1, e[3:0]});
      slot(1'b1, 4'hF);
      chk(got_oe && got_dat == e[7:4], {tag, " R7 high nibble"}, {got_oe, got_dat}, {1'b1, e[7:4]});
    end
    slot(1'b1, 4'hF);
    chk(got_oe && got_dat == 4'hF, {tag, " R7 end drive"}, {got_oe, got_dat}, 5'h1F);
    slot(1'b1, 4'hF);
    chk(!got_oe, {tag, " R7 release"}, got_oe, 0);
  endtask

  task automatic do_write(input logic [3:0] id, input logic [27:0] a, input logic [3:0] szc,
                          input int n, input bit resp, input string tag);
    bit quiet = 1'b1;
    header(4'hE, id, a, szc);
    for (int i = 0; i < n; i++) begin
      slot(1'b1, wbuf[i][3:0]);
      if (got_oe) quiet = 1'b0;
      slot(1'b1, wbuf[i][7:4]);
      if (got_oe) quiet = 1'b0;
    end
    slot(1'b1, 4'hF);
    if (got_oe) quiet = 1'b0;
    slot(1'b1, 4'hF);
    if (got_oe) quiet = 1'b0;
    chk(quiet, {tag, " R8 quiet during data"}, quiet, 1);
    slot(1'b1, 4'hF);
    if (resp) begin
      chk(got_oe && got_dat == 4'h0, {tag, " R8 sync nibble"}, {got_oe, got_dat}, 5'h10);
      slot(1'b1, 4'hF);
      chk(got_oe && got_dat == 4'hF, {tag, " R8 end drive"}, {got_oe, got_dat}, 5'h1F);
      slot(1'b1, 4'hF);
      chk(!got_oe, {tag, " R8 release"}, got_oe, 0);
      for (int i = 0; i < n; i++) exp_mem[8'(a[7:0] + 8'(i))] = wbuf[i];
    end else begin
      quiet = !got_oe;
      for (int i = 0; i < 2; i++) begin
        slot(1'b1, 4'hF);
        if (got_oe) quiet = 1'b0;
      end
      chk(quiet, {tag, " rejected write stays off bus"}, quiet, 1);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!lad_oe, "R1 bus quiet in reset", lad_oe, 0);
    rst_n = 1'b1;
    repeat (2) slot(1'b1, 4'hF);
    chk(!got_oe, "R1 bus quiet after reset", got_oe, 0);
  endtask

  task automatic t_single;
    fill(1, 1);
    do_write(DEV, 28'h0000005, 4'h0, 1, 1'b1, "R8 single byte");
    do_read(DEV, 28'h0000005, 4'h0, 1, 1'b1, "R2 single byte");
  endtask

  task automatic t_bursts;
    fill(4, 2);
    do_write(DEV, 28'h0000010, 4'h2, 4, 1'b1, "R8 four bytes");
    do_read(DEV, 28'h0000010, 4'h2, 4, 1'b1, "R7 four bytes");
    fill(16, 3);
    do_write(DEV, 28'h0000020, 4'h4, 16, 1'b1, "R5 sixteen bytes");
    do_read(DEV, 28'h0000022, 4'h1, 2, 1'b1, "R5 two bytes");
    do_read(DEV, 28'h0000020, 4'h4, 16, 1'b1, "R5 sixteen read");
    fill(128, 4);
    do_write(DEV, 28'h0000080, 4'h7, 128, 1'b1, "R5 full burst");
    do_read(DEV, 28'h0000080, 4'h7, 128, 1'b1, "R7 full burst");
  endtask

  task automatic t_alias;
    fill(1, 9);
    do_write(DEV, 28'hABCDE07, 4'h0, 1, 1'b1, "R4 high bits set");
    do_read(DEV, 28'h0000007, 4'h0, 1, 1'b1, "R4 aliased read");
  endtask

  task automatic t_reject;
    do_read(4'h9, 28'h0000010, 4'h2, 4, 1'b0, "R3 foreign select");
    fill(4, 20);
    do_write(4'h9, 28'h0000010, 4'h2, 4, 1'b0, "R3 foreign write");
    do_read(DEV, 28'h0000010, 4'h3, 8, 1'b0, "R5 bad size code");
    do_write(DEV, 28'h0000010, 4'h3, 4, 1'b0, "R5 bad size write");
    do_read(DEV, 28'h0000012, 4'h2, 4, 1'b0, "R6 misaligned read");
    do_write(DEV, 28'h0000012, 4'h2, 4, 1'b0, "R6 misaligned write");
    do_read(DEV, 28'h0000010, 4'h2, 4, 1'b1, "R3 R5 R6 array unchanged");
    begin
      bit quiet = 1'b1;
      header(4'h2, DEV, 28'h0000010, 4'h0);
      for (int i = 0; i < 6; i++) begin
        slot(1'b1, 4'hF);
        if (got_oe) quiet = 1'b0;
      end
      chk(quiet, "R2 foreign start ignored", quiet, 1);
    end
    slot(1'b0, 4'h5);
    do_read(DEV, 28'h0000005, 4'h0, 1, 1'b1, "R2 last low-frame nibble");
  endtask

  task automatic t_abort;
    fill(4, 30);
    do_write(DEV, 28'h0000040, 4'h2, 4, 1'b1, "R9 prefill");
    header(4'hE, DEV, 28'h0000040, 4'h2);
    slot(1'b1, 4'h1);
    slot(1'b1, 4'h2);
    slot(1'b1, 4'h3);
    slot(1'b0, 4'h0);
    slot(1'b1, 4'hF);
    chk(!got_oe, "R9 write abort releases", got_oe, 0);
    exp_mem[8'h40] = 8'h21;
    do_read(DEV, 28'h0000040, 4'h2, 4, 1'b1, "R9 whole bytes kept");
    header(4'hD, DEV, 28'h0000040, 4'h2);
    repeat (3) slot(1'b1, 4'hF);
    slot(1'b1, 4'hF);
    slot(1'b0, 4'hF);
    chk(got_oe, "R9 read in progress before abort", got_oe, 1);
    slot(1'b1, 4'hF);
    chk(!got_oe, "R9 read abort releases", got_oe, 0);
    slot(1'b1, 4'hF);
    chk(!got_oe, "R9 stays released", got_oe, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_bursts();
    t_alias();
    t_reject();
    t_abort();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule